// File: doc/BRIEF.md
# DS3 Overhead Error Injector

This block sits in the serial transmit path of a DS3 framer, after the overhead bits have been computed. It passes the serial bit stream through unchanged until a test request asks for a single corrupted event. A shared frame counter supplies the position of the current bit within the 4760-bit frame. There are four kinds of request: an overhead-bit error, a P-bit parity error, a C-bit parity error and a far-end block error (FEBE). Each request corrupts exactly one group or one frame and then stops.

The frame is seven subframes of 680 bits. Each subframe holds eight 85-bit groups, and the first bit of each group is an overhead bit. The block raises a window output on the last bit of every group. A low overhead-force input seen during that window inverts the overhead bit that follows. Parity and FEBE requests are tied to frames. A falling edge on their force inputs queues the request, and the whole next frame carries the error. The C-bit parity and FEBE requests apply only in C-bit parity mode.

Top module: `ds3oh_inject`

## Requirements
- R1: After reset no request is queued and no overhead error is armed. `bit_out` equals `bit_in` until a request is made.
- R2: `oh_win` is high exactly in the cycles where `bit_idx` mod 85 equals 84.
- R3: A cycle with `oh_win` high, `force_oh_n` low and no error taken during the current low period inverts `bit_out` in the next cycle only. That cycle is an overhead bit position (`bit_idx` mod 85 = 0).
- R4: While `force_oh_n` stays low after it has produced an error, further windows produce no error. A new error needs `force_oh_n` to be sampled high first.
- R5: A falling edge on `force_p_n` (low in a cycle after a cycle in which it was high) queues a P-bit request. The frame that starts after the edge cycle inverts both P-bits, at positions 1360 and 2040. An edge in the cycle with `bit_idx` = 0 applies to the following frame.
- R6: A falling edge on `force_cp_n` in C-bit parity mode (`cbit_mode` = 1) inverts the three CP bits of the next frame, at positions 1530, 1700 and 1870.
- R7: A falling edge on `force_febe_n` in C-bit parity mode drives the three FEBE bits of the next frame to 0, at positions 2210, 2380 and 2550.
- R8: In M13 mode (`cbit_mode` = 0), edges on `force_cp_n` and `force_febe_n` are dropped and leave nothing queued. CP and FEBE positions pass through unchanged in an M13 frame.
- R9: A force input held low for many frames, or pulsed several times before a frame start, produces errors in one frame only.
- R10: When an overhead error lands on a bit that a frame request also altered, the overhead error inverts the already altered value.
- R11: Every bit not targeted by R3, R5, R6 or R7 leaves with the value of `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cbit_mode | input | 1 | 1 selects C-bit parity mode, 0 selects M13 mode |
| bit_idx | input | 13 | Position of the current bit in the frame, 0 to 4759, advancing by one each clock |
| bit_in | input | 1 | Serial bit with correct overhead |
| force_oh_n | input | 1 | Overhead-bit error request, active low |
| force_p_n | input | 1 | P-bit parity error request, active low |
| force_cp_n | input | 1 | C-bit parity error request, active low |
| force_febe_n | input | 1 | FEBE error request, active low |
| bit_out | output | 1 | Serial bit after injection |
| oh_win | output | 1 | Window in which an overhead request is accepted |

## Verification
An overhead error and a frame-level error can hit the same cycle. This happens when the overhead window just before a P-bit or FEBE group is used in a frame that also carries a P or FEBE request. The bench provokes both cases in one frame by queuing P, CP and FEBE requests in the frame before it, then holding the overhead force low across the windows at positions 1359 and 2209. It judges the result by expecting the original bit at position 1360, because two inversions cancel, and a 1 at position 2210, the forced zero inverted. All other bits of that frame must follow the reference model.

// File: rtl/ds3oh_pkg.sv
package ds3oh_pkg;

  localparam int GRP_BITS_DEF  = 85;
  localparam int SUBF_GRPS_DEF = 8;
  localparam int SUBFRAMES_DEF = 7;

  typedef enum int {
    K_PBIT = 0,
    K_CPAR = 1,
    K_FEBE = 2
  } ds3oh_kind_e;

  localparam int NKIND = 3;

  // first bit of group blk in subframe sf (both zero based)
  function automatic int oh_addr(int grp, int sgrps, int sf, int blk);
    return (sf * sgrps + blk) * grp;
  endfunction

  function automatic logic grp_last(int idx, int grp);
    return (idx % grp) == (grp - 1);
  endfunction

  function automatic logic grp_first(int idx, int grp);
    return (idx % grp) == 0;
  endfunction

  // the three C-bits of subframe sf sit in groups 2, 4 and 6
  function automatic logic c_slot(int idx, int grp, int sgrps, int sf);
    return (idx == oh_addr(grp, sgrps, sf, 2)) ||
           (idx == oh_addr(grp, sgrps, sf, 4)) ||
           (idx == oh_addr(grp, sgrps, sf, 6));
  endfunction

  // P-bits lead subframes 3 and 4
  function automatic logic p_slot(int idx, int grp, int sgrps);
    return (idx == oh_addr(grp, sgrps, 2, 0)) ||
           (idx == oh_addr(grp, sgrps, 3, 0));
  endfunction

endpackage

// File: rtl/ds3oh_frame_req.sv
module ds3oh_frame_req (
  input  logic clk,
  input  logic rst_n,
  input  logic force_n,
  input  logic allow,
  input  logic at_start,
  output logic act
);
  logic prev_q, pend_q, act_q;
  logic fall;

  assign fall = prev_q & ~force_n & allow;
  assign act  = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      prev_q <= force_n;
      if (at_start) begin
        act_q  <= pend_q;
        pend_q <= fall;
      end else begin
        pend_q <= pend_q | fall;
      end
    end
  end

  // R9: the active frame flag moves only on a frame boundary
  p_act_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(at_start));

  // R5: a queued request becomes active at the frame start
  p_pend_to_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_start && pend_q) |=> act_q);

endmodule

// File: rtl/ds3oh_oh_stage.sv
module ds3oh_oh_stage
  import ds3oh_pkg::*;
#(
  parameter int GRP_BITS = GRP_BITS_DEF,
  parameter int IDXW     = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            force_n,
  output logic            win,
  output logic            oh_now
);
  logic used_q, now_q, fire;

  assign win    = grp_last(int'(bit_idx), GRP_BITS);
  assign fire   = win & ~force_n & ~used_q;
  assign oh_now = now_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= 1'b0;
      now_q  <= 1'b0;
    end else begin
      used_q <= force_n ? 1'b0 : (used_q | fire);
      now_q  <= fire;
    end
  end

  // R3: an overhead error lasts one bit and follows a window
  p_oh_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oh_now |=> !oh_now);
  p_oh_after_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oh_now |-> $past(win));

  // R4: no second error while the request stays low
  p_oh_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_now && !force_n) |=> (!oh_now until_with force_n));

endmodule

// File: rtl/ds3oh_inject.sv
module ds3oh_inject
  import ds3oh_pkg::*;
#(
  parameter  int GRP_BITS   = GRP_BITS_DEF,
  parameter  int SUBF_GRPS  = SUBF_GRPS_DEF,
  parameter  int SUBFRAMES  = SUBFRAMES_DEF,
  localparam int FRAME_BITS = GRP_BITS * SUBF_GRPS * SUBFRAMES,
  localparam int IDXW       = $clog2(FRAME_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cbit_mode,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            bit_in,
  input  logic            force_oh_n,
  input  logic            force_p_n,
  input  logic            force_cp_n,
  input  logic            force_febe_n,
  output logic            bit_out,
  output logic            oh_win
);
  logic [NKIND-1:0] force_vec, allow_vec, act_vec;
  logic at_start, oh_now;
  logic p_hit, cp_hit, febe_hit, frame_bit;
  int   idx;

  assign idx      = int'(bit_idx);
  assign at_start = (bit_idx == '0);

  assign force_vec[K_PBIT] = force_p_n;
  assign force_vec[K_CPAR] = force_cp_n;
  assign force_vec[K_FEBE] = force_febe_n;
  assign allow_vec[K_PBIT] = 1'b1;
  assign allow_vec[K_CPAR] = cbit_mode;
  assign allow_vec[K_FEBE] = cbit_mode;

  for (genvar g = 0; g < NKIND; g++) begin : g_req
    ds3oh_frame_req u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_n  (force_vec[g]),
      .allow    (allow_vec[g]),
      .at_start (at_start),
      .act      (act_vec[g])
    );
  end

  ds3oh_oh_stage #(.GRP_BITS(GRP_BITS), .IDXW(IDXW)) u_oh (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_idx (bit_idx),
    .force_n (force_oh_n),
    .win     (oh_win),
    .oh_now  (oh_now)
  );

  assign p_hit    = act_vec[K_PBIT] & p_slot(idx, GRP_BITS, SUBF_GRPS);
  assign cp_hit   = act_vec[K_CPAR] & cbit_mode & c_slot(idx, GRP_BITS, SUBF_GRPS, 2);
  assign febe_hit = act_vec[K_FEBE] & cbit_mode & c_slot(idx, GRP_BITS, SUBF_GRPS, 3);

  // frame-level errors first, then the overhead inversion on top (R10)
  assign frame_bit = febe_hit ? 1'b0 : (bit_in ^ (p_hit | cp_hit));
  assign bit_out   = frame_bit ^ oh_now;

  // R3: overhead errors land only on overhead bit positions
  p_oh_on_oh_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oh_now |-> grp_first(idx, GRP_BITS));

  // R8: in M13 mode only P-bits and overhead errors may alter the stream
  p_m13_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbit_mode && !oh_now && !p_slot(idx, GRP_BITS, SUBF_GRPS)) |-> (bit_out == bit_in));

  // R11: payload bits are never touched
  p_payload_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_first(idx, GRP_BITS) |-> (bit_out == bit_in));

endmodule

// File: tb/tb_ds3oh_inject.sv
module tb_ds3oh_inject;
  localparam int FB = 4760;
  localparam int NFRAMES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cbit_mode = 1'b1;
  logic [12:0] bit_idx = '0;
  logic bit_in = 1'b0;
  logic force_oh_n = 1'b1, force_p_n = 1'b1, force_cp_n = 1'b1, force_febe_n = 1'b1;
  logic bit_out, oh_win;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ds3oh_inject dut (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .bit_idx(bit_idx),
    .bit_in(bit_in), .force_oh_n(force_oh_n), .force_p_n(force_p_n),
    .force_cp_n(force_cp_n), .force_febe_n(force_febe_n),
    .bit_out(bit_out), .oh_win(oh_win)
  );

  task automatic chk(input string req, input int f, input int i, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s frame %0d bit %0d actual %0b expected %0b", req, f, i, act, exp);
    end
  endtask

  // reference model state
  bit want_p[NFRAMES+2];
  bit want_cp[NFRAMES+2];
  bit want_fb[NFRAMES+2];
  bit lp = 1, lc = 1, lf = 1;
  bit oh_taken = 0, oh_flip = 0;

  function automatic bit is_p(int i);   return i == 2*680 || i == 3*680; endfunction
  function automatic bit is_cp(int i);  return i == 1360+170 || i == 1360+340 || i == 1360+510; endfunction
  function automatic bit is_fb(int i);  return i == 2040+170 || i == 2040+340 || i == 2040+510; endfunction

  initial begin
    for (int k = 0; k < NFRAMES + 2; k++) begin
      want_p[k] = 0; want_cp[k] = 0; want_fb[k] = 0;
    end
    // reset phase, R1
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      bit_in = c[0];
      #1;
      chk("R1", -1, 0, bit_out, bit_in);
      chk("R1", -1, 0, oh_win, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < NFRAMES; f++) begin
      for (int i = 0; i < FB; i++) begin
        logic e, flip_fr;
        bit win, fire;
        string tag;
        @(negedge clk);
        bit_idx = 13'(i);
        bit_in = 1'($urandom_range(0, 1));
        cbit_mode = (f != 3);
        force_p_n  = !((f == 0 && i >= 100 && i < 103) || (f == 1 && i >= 50) || f == 2 ||
                       (f == 3 && i >= 10 && i < 13) || (f == 5 && i >= 500 && i < 502));
        force_cp_n = !((f == 0 && i >= 200 && i < 202) || (f == 2 && i >= 900 && i < 902) ||
                       (f == 3 && i >= 300 && i < 302) || (f == 5 && i < 2));
        force_febe_n = !((f == 0 && i == FB-1) || (f == 3 && i >= 400 && i < 402) ||
                         (f == 5 && i >= 600 && i < 603));
        force_oh_n = !((f == 1 && i >= 160 && i <= 175) || (f == 2 && i >= 300 && i <= 700) ||
                       (f == 6 && i >= 1355 && i <= 1362) || (f == 6 && i >= 2205 && i <= 2212));
        #1;
        // expected output
        flip_fr = (want_p[f] && is_p(i)) || (want_cp[f] && cbit_mode && is_cp(i));
        if (want_fb[f] && cbit_mode && is_fb(i)) e = 1'b0;
        else e = bit_in ^ flip_fr;
        e = e ^ oh_flip;
        win = (i % 85) == 84;
        if (oh_flip) tag = "R3";
        else if (is_p(i)) tag = "R5";
        else if (is_cp(i)) tag = "R6";
        else if (is_fb(i)) tag = "R7";
        else tag = "R11";
        chk(tag, f, i, bit_out, e);
        chk("R2", f, i, oh_win, win);
        // directed observations
        if (f == 2 && i == 425) chk("R4", f, i, bit_out, bit_in);
        if (f == 1 && i == 170) chk("R3", f, i, bit_out, ~bit_in);
        if (f == 3 && (i == 1530 || i == 2210)) chk("R8", f, i, bit_out, bit_in);
        if (f == 4 && (i == 1530 || i == 2380)) chk("R8", f, i, bit_out, bit_in);
        if (f == 4 && i == 2040) chk("R5", f, i, bit_out, ~bit_in);
        if (f == 3 && i == 1360) chk("R9", f, i, bit_out, bit_in);
        if (f == 2 && i == 2040) chk("R9", f, i, bit_out, ~bit_in);
        if (f == 6 && i == 1360) chk("R10", f, i, bit_out, bit_in);
        if (f == 6 && i == 2210) chk("R10", f, i, bit_out, 1'b1);
        if (f == 6 && i == 1700) chk("R6", f, i, bit_out, ~bit_in);
        if (f == 1 && i == 2550) chk("R7", f, i, bit_out, 1'b0);
        // model update for what the design sees this cycle
        if (lp && !force_p_n) want_p[f+1] = 1;
        if (lc && !force_cp_n && cbit_mode) want_cp[f+1] = 1;
        if (lf && !force_febe_n && cbit_mode) want_fb[f+1] = 1;
        lp = force_p_n; lc = force_cp_n; lf = force_febe_n;
        fire = win && !force_oh_n && !oh_taken;
        oh_taken = force_oh_n ? 0 : (oh_taken | fire);
        oh_flip = fire;
      end
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule